// File: doc/BRIEF.md
# Resynchronising Feedback Divider

This block forms the digital feedback path of a clock loop that tracks a reference input. The oscillator-derived clock is the block's own clock. A pre-divider counts that clock down by a static ratio. A wide main divider then counts pre-divider ticks and emits one feedback pulse per full count. A downstream phase detector compares that pulse against the reference. The block also drives a correction-enable output that tells the detector whether it may steer the loop.

An active-low clear input handles a change of reference. While clear is held low, correction is switched off and the divider stops producing pulses. When clear is released, correction comes back at once. The main divider, however, is emptied and waits for the first rising edge of the reference before it counts again. The new reference phase therefore starts a fresh count, and no history from the old reference remains. The pre-divider is never touched by clear.

Both ratio codes are static pins. Each divider takes its code only at the end of its own cycle, so a code change never leaves a short cycle.

Top module: `fbdiv_resync`

## Requirements
- R1: The pre-divider emits one tick every code+2 clock cycles for a 6-bit code (ratios 2 to 65).
- R2: The main divider takes a 12-bit code. Codes 0 to 4094 divide the pre-divider ticks by code+2, and the all-ones code 4095 divides by 1. The feedback pulse period in clock cycles is therefore the product of the two ratios.
- R3: While clear is low, `corr_en` is low and no feedback pulse is produced, whatever the reference does.
- R4: After clear is released, or after reset, no feedback pulse appears until a rising reference edge is seen. After that edge, pulses follow at the full period.
- R5: The pre-divider keeps running through a clear sequence, so pulses after resynchronisation stay on the same pre-divider tick grid as before.
- R6: `corr_en` returns high within three clock cycles of clear going high, without waiting for a reference edge.
- R7: Each feedback pulse is exactly one clock cycle wide.
- R8: Each divider samples its code only at its own terminal count. After a change, every period equals either the full old period or the full new period.
- R9: The reference passes through a two-flop synchroniser and an edge detector. Reference activity while the divider is running has no effect on the pulse period.
- R10: Synchronous active-high reset leaves `fb_pulse` low, `corr_en` high, and the main divider waiting for a reference edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Active-low clear; low suspends correction, and its release resynchronises the divider |
| ref_in | input | 1 | Reference clock, asynchronous |
| pre_code | input | 6 | Pre-divider code, ratio code+2 |
| fb_code | input | 12 | Main divider code, ratio code+2, all-ones gives 1 |
| fb_pulse | output | 1 | One-cycle feedback pulse |
| corr_en | output | 1 | Correction enable for the phase detector |

## Verification
On every cycle, the assertions check the following:
- both counters stay within their latched limits;
- pre-divider ticks are never back to back;
- feedback pulses are one cycle wide;
- a waiting or held divider emits nothing;
- disabled correction is never followed by a pulse.

Only the bench scenarios can show the behaviours that span many cycles. These are the exact period for each code pair, and the restart only on a reference edge after clear. They also include the grid of ticks kept across a clear and the clean switch of period after a code change.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    localparam int PRE_CODE_W  = 6;
    localparam int FB_CODE_W   = 12;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } fb_state_e;

endpackage

// File: rtl/fbdiv_sync.sv
module fbdiv_sync #(
    parameter int STAGES    = 2,
    parameter bit RST_VAL   = 1'b0,
    parameter bit RISE_ONLY = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= {STAGES{RST_VAL}};
        else     sh <= {sh[STAGES-2:0], d};
    end

    generate
        if (RISE_ONLY) begin : g_rise
            logic last;
            always_ff @(posedge clk) begin
                if (rst) last <= RST_VAL;
                else     last <= sh[STAGES-1];
            end
            assign q = sh[STAGES-1] & ~last;

            AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
                q |=> !q); // R9
        end else begin : g_level
            assign q = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/fbdiv_prediv.sv
module fbdiv_prediv #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] code,
    output logic         tick
);
    logic [W:0] pcnt;
    logic [W:0] plim;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
            plim <= {1'b0, code} + (W+1)'(1);
        end else if (pcnt == plim) begin
            pcnt <= '0;
            plim <= {1'b0, code} + (W+1)'(1);
        end else begin
            pcnt <= pcnt + (W+1)'(1);
        end
    end

    assign tick = (pcnt == plim);

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
        pcnt <= plim); // R1
    AST_PRE_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R1
endmodule

// File: rtl/fbdiv_main.sv
module fbdiv_main
    import fbdiv_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_ok,
    input  logic         ref_rise,
    input  logic         pre_tick,
    input  logic [W-1:0] code,
    output logic         fb_pulse,
    output logic         corr_en
);
    localparam logic [W-1:0] BYPASS_CODE = '1;

    function automatic logic [W:0] limit_of(input logic [W-1:0] c);
        if (c == BYPASS_CODE) return '0;
        return {1'b0, c} + (W+1)'(1);
    endfunction

    fb_state_e  st;
    logic [W:0] mcnt;
    logic [W:0] mlim;
    logic       pulse_q;
    logic       corr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_ARMED;
            mcnt    <= '0;
            mlim    <= limit_of(code);
            pulse_q <= 1'b0;
            corr_q  <= 1'b1;
        end else begin
            pulse_q <= 1'b0;
            corr_q  <= clr_ok;
            if (!clr_ok) begin
                st <= ST_HOLD;
            end else begin
                case (st)
                    ST_HOLD: begin
                        st   <= ST_ARMED;
                        mcnt <= '0;
                    end
                    ST_ARMED: begin
                        if (ref_rise) begin
                            st   <= ST_RUN;
                            mcnt <= '0;
                            mlim <= limit_of(code);
                        end
                    end
                    ST_RUN: begin
                        if (pre_tick) begin
                            if (mcnt == mlim) begin
                                mcnt    <= '0;
                                mlim    <= limit_of(code);
                                pulse_q <= 1'b1;
                            end else begin
                                mcnt <= mcnt + (W+1)'(1);
                            end
                        end
                    end
                    default: st <= ST_ARMED;
                endcase
            end
        end
    end

    assign fb_pulse = pulse_q;
    assign corr_en  = corr_q;

    AST_MCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        mcnt <= mlim); // R2
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        fb_pulse |=> !fb_pulse); // R7
    AST_ARMED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ARMED) |=> !fb_pulse); // R4
    AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (rst)
        !corr_en |=> !fb_pulse); // R3
endmodule

// File: rtl/fbdiv_resync.sv
module fbdiv_resync
    import fbdiv_pkg::*;
#(
    parameter int PRE_W = PRE_CODE_W,
    parameter int FB_W  = FB_CODE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n,
    input  logic             ref_in,
    input  logic [PRE_W-1:0] pre_code,
    input  logic [FB_W-1:0]  fb_code,
    output logic             fb_pulse,
    output logic             corr_en
);
    logic ref_rise;
    logic clr_ok;
    logic pre_tick;

    fbdiv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .RISE_ONLY(1'b1)) u_ref_sync (
        .clk(clk), .rst(rst), .d(ref_in), .q(ref_rise)
    );

    fbdiv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .RISE_ONLY(1'b0)) u_clr_sync (
        .clk(clk), .rst(rst), .d(clr_n), .q(clr_ok)
    );

    fbdiv_prediv #(.W(PRE_W)) u_prediv (
        .clk(clk), .rst(rst), .code(pre_code), .tick(pre_tick)
    );

    fbdiv_main #(.W(FB_W)) u_main (
        .clk(clk), .rst(rst), .clr_ok(clr_ok), .ref_rise(ref_rise),
        .pre_tick(pre_tick), .code(fb_code),
        .fb_pulse(fb_pulse), .corr_en(corr_en)
    );
endmodule

// File: tb/fbdiv_resync_tb.sv
module fbdiv_resync_tb;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_n = 1'b1;
    logic        ref_in = 1'b0;
    logic [5:0]  pre_code = '0;
    logic [11:0] fb_code = '0;
    logic        fb_pulse;
    logic        corr_en;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    typedef struct packed {
        logic [5:0]  pre;
        logic [11:0] fb;
        logic [31:0] per;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{6'd0,  12'd0,    32'd4},
        '{6'd3,  12'd5,    32'd35},
        '{6'd0,  12'd4095, 32'd2},
        '{6'd63, 12'd0,    32'd130},
        '{6'd1,  12'd4095, 32'd3},
        '{6'd2,  12'd10,   32'd48},
        '{6'd0,  12'd4094, 32'd8192}
    };

    fbdiv_resync u_dut (
        .clk(clk), .rst(rst), .clr_n(clr_n), .ref_in(ref_in),
        .pre_code(pre_code), .fb_code(fb_code),
        .fb_pulse(fb_pulse), .corr_en(corr_en)
    );

    always #(CLK_NS/2) clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cycles(3);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic ref_edge();
        ref_in = 1'b1;
        cycles(4);
        ref_in = 1'b0;
        cycles(2);
    endtask

    task automatic wait_pulse(input int limit, output int at);
        at = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (fb_pulse) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic count_pulses(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (fb_pulse) cnt++;
        end
    endtask

    initial begin
        #(CLK_NS * 190000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int t0, t1, t2, cnt, lim;

        // Table of code pairs and expected periods: R1, R2, R4, R10
        for (int v = 0; v < NV; v++) begin
            pre_code = VECS[v].pre;
            fb_code  = VECS[v].fb;
            do_reset();
            check(fb_pulse == 1'b0, "R10 pulse after reset", fb_pulse, 0);
            check(corr_en == 1'b1, "R10 corr_en after reset", corr_en, 1);
            count_pulses(40, cnt);
            check(cnt == 0, "R4 no pulse before reference edge", cnt, 0);
            ref_edge();
            lim = 2 * int'(VECS[v].per) + 100;
            wait_pulse(lim, t0);
            wait_pulse(lim, t1);
            wait_pulse(lim, t2);
            check(t0 >= 0 && t1 - t0 == int'(VECS[v].per), "R1/R2 period a", t1 - t0, int'(VECS[v].per));
            check(t0 >= 0 && t2 - t1 == int'(VECS[v].per), "R2 period b", t2 - t1, int'(VECS[v].per));
        end

        // R7: one-cycle pulse
        pre_code = 6'd1; fb_code = 12'd3;
        do_reset();
        ref_edge();
        wait_pulse(100, t0);
        @(negedge clk);
        check(t0 >= 0 && fb_pulse == 1'b0, "R7 pulse width", fb_pulse, 0);

        // R3, R6, R4: clear sequence
        wait_pulse(100, t0);
        clr_n = 1'b0;
        cycles(4);
        check(corr_en == 1'b0, "R3 corr_en while clear low", corr_en, 0);
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            ref_in = ~ref_in;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (fb_pulse) cnt++;
            end
        end
        ref_in = 1'b0;
        check(cnt == 0, "R3 pulses while clear low", cnt, 0);
        check(corr_en == 1'b0, "R3 corr_en still low", corr_en, 0);
        clr_n = 1'b1;
        cycles(3);
        check(corr_en == 1'b1, "R6 corr_en after release", corr_en, 1);
        count_pulses(100, cnt);
        check(cnt == 0, "R4 waits for reference after clear", cnt, 0);
        ref_edge();
        wait_pulse(100, t1);
        wait_pulse(100, t2);
        check(t1 >= 0 && t2 - t1 == 15, "R4 period after resync", t2 - t1, 15);

        // R5: pre-divider grid kept across clear
        pre_code = 6'd4; fb_code = 12'd4095;
        do_reset();
        ref_edge();
        wait_pulse(100, t0);
        clr_n = 1'b0;
        cycles(37);
        clr_n = 1'b1;
        cycles(5);
        ref_edge();
        wait_pulse(100, t1);
        check(t0 >= 0 && t1 >= 0 && (t1 - t0) % 6 == 0, "R5 tick grid offset", (t1 - t0) % 6, 0);

        // R8: code change applies at terminal count
        pre_code = 6'd0; fb_code = 12'd5;
        do_reset();
        ref_edge();
        wait_pulse(100, t0);
        fb_code = 12'd2;
        wait_pulse(100, t1);
        wait_pulse(100, t2);
        check(t1 - t0 == 14, "R8 old period after change", t1 - t0, 14);
        check(t2 - t1 == 8, "R8 new period after change", t2 - t1, 8);

        // R9: reference activity while running is ignored
        pre_code = 6'd1; fb_code = 12'd6;
        do_reset();
        ref_edge();
        wait_pulse(200, t0);
        cycles(5);
        ref_edge();
        ref_edge();
        wait_pulse(200, t1);
        wait_pulse(200, t2);
        check(t1 - t0 == 24, "R9 period with ref toggling a", t1 - t0, 24);
        check(t2 - t1 == 24, "R9 period with ref toggling b", t2 - t1, 24);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule